// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is a small accumulator processor built as a control state machine plus an explicit register-transfer datapath. It holds a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. It walks every instruction through a fixed series of subcycles: fetch, an optional indirect subcycle, execute, a check point, and an optional interrupt-entry subcycle. It talks to one synchronous single-port memory. Read data comes back one clock after the read request.

Instruction words are 16 bits wide. Bits 15:13 hold the operation and bit 12 selects indirect operand addressing. Bits 11:0 hold an address. The indirect subcycle replaces that address with the low 12 bits of the memory word it points at. At the check point after execute, a pending interrupt request is taken only while the internal interrupt-enable flag is set. Entry saves the program counter through the buffer register to a fixed save word, then jumps to a fixed handler start. A handler can return with an indirect jump through the save word.

Every state lasts one clock. An instruction therefore takes a known number of cycles:
- fetch: 4
- indirect: 3
- execute for load and add: 4
- execute for every other code: 1
- check point: 1
- interrupt entry: 3

Top module: `instr_cycle_seq`

## Requirements
- R1: While `rst` is high, on each clock edge `pc`, `ir`, `acc`, `flag_z`, `flag_c`, `ien`, `mem_rd`, `mem_wr` and `int_done` are all cleared to zero. The cycle after reset falls is the first fetch cycle.
- R2: Fetch copies `pc` into the address register and issues a read at that address. It increments `pc` by one in that same cycle. The returned word goes into the buffer register and from there into `ir`. A fetch takes 4 cycles.
- R3: When instruction bit 12 is 1, an indirect subcycle of 3 cycles follows the fetch. It reads memory at the word's bits 11:0, and bits 11:0 of the data read become the operand address. When bit 12 is 0, bits 11:0 are used directly.
- R4: Operation code 001 loads the accumulator from the operand address. It sets `flag_z` when the loaded value is zero and leaves `flag_c` unchanged. Its execute phase takes 4 cycles.
- R5: Operation code 011 adds the word at the operand address to the accumulator, modulo 2^16. `flag_c` takes the carry out of bit 15 and `flag_z` is set when the sum is zero. Its execute phase takes 4 cycles.
- R6: Operation code 010 writes the accumulator to the operand address. It issues exactly one write with `mem_wr` high. Its execute phase takes 1 cycle.
- R7: Operation code 100 loads `pc` with the operand address. Code 000 and the unused codes 101, 110 and 111 change nothing except the fetch increment of `pc`. Each of these takes 1 execute cycle.
- R8: One check cycle follows every execute phase. Interrupt entry starts only from the check cycle, and only when `irq` and `ien` are both high there. Otherwise the next fetch starts.
- R9: Interrupt entry takes 3 cycles and writes the current `pc` to address 0x000. It then sets `pc` to 0x001, clears `ien` and holds `int_done` high for exactly one cycle.
- R10: A one-cycle pulse on `ie_set` sets `ien`. `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| irq | input | 1 | interrupt request level |
| ie_set | input | 1 | pulse that sets the interrupt-enable flag |
| mem_rdata | input | 16 | memory read data, valid one cycle after a read request |
| mem_addr | output | 12 | memory address (address register) |
| mem_wdata | output | 16 | memory write data (buffer register) |
| mem_rd | output | 1 | read request |
| mem_wr | output | 1 | write request |
| pc | output | 12 | program counter |
| ir | output | 16 | instruction register |
| acc | output | 16 | accumulator |
| flag_z | output | 1 | zero flag |
| flag_c | output | 1 | carry flag |
| ien | output | 1 | interrupt-enable flag |
| int_done | output | 1 | one-cycle pulse when interrupt entry completes |

## Verification
The program mixes direct and indirect forms of load, add and store.
- If the indirect subcycle is skipped or mis-addressed, the effective address is wrong, so the wrong operand lands in the accumulator or a store goes to the wrong word.
- An add that wraps to zero tests that both flags update. A later load then tests that carry is left alone; a design that clears or recomputes carry on load shows a changed `flag_c`.

The interrupt tests cover three cases:
- a request while interrupts are disabled, which must not divert the program;
- a request that is still held inside the handler after entry has cleared the enable, where re-entering would corrupt the save word;
- a normal entry followed by a return through the saved address, where a wrong saved value sends the program to the wrong resume point.

Every memory write is matched against the expected address and data.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [3:0] {
    S_FA,  // fetch: address out, read issued, pc step
    S_FW,  // fetch: memory busy
    S_FC,  // fetch: capture into buffer
    S_FI,  // fetch: buffer into instruction register
    S_IA,  // indirect: address out, read issued
    S_IW,  // indirect: memory busy
    S_IC,  // indirect: capture effective address
    S_XA,  // execute: first step
    S_XW,  // execute: memory busy
    S_XC,  // execute: capture operand
    S_XD,  // execute: update accumulator
    S_CK,  // check point for interrupts
    S_NA,  // interrupt: pc into buffer
    S_NB,  // interrupt: save address, write
    S_NC   // interrupt: vector to handler
  } isc_state_e;

  localparam logic [2:0] OP_NOP = 3'b000;
  localparam logic [2:0] OP_LDA = 3'b001;
  localparam logic [2:0] OP_STA = 3'b010;
  localparam logic [2:0] OP_ADD = 3'b011;
  localparam logic [2:0] OP_JMP = 3'b100;

  function automatic logic op_reads(input logic [2:0] op);
    return (op == OP_LDA) || (op == OP_ADD);
  endfunction

endpackage

// File: rtl/isc_alu.sv
module isc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[DW-1:0];
    cout = wide[DW];
  end
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] op,
  input  logic       ind,
  input  logic       irq,
  input  logic       ien,
  output isc_state_e state
);
  isc_state_e nxt;

  always_comb begin
    nxt = S_FA;
    unique case (state)
      S_FA: nxt = S_FW;
      S_FW: nxt = S_FC;
      S_FC: nxt = S_FI;
      S_FI: nxt = ind ? S_IA : S_XA;
      S_IA: nxt = S_IW;
      S_IW: nxt = S_IC;
      S_IC: nxt = S_XA;
      S_XA: nxt = op_reads(op) ? S_XW : S_CK;
      S_XW: nxt = S_XC;
      S_XC: nxt = S_XD;
      S_XD: nxt = S_CK;
      S_CK: nxt = (irq && ien) ? S_NA : S_FA;
      S_NA: nxt = S_NB;
      S_NB: nxt = S_NC;
      S_NC: nxt = S_FA;
      default: nxt = S_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FA;
    else     state <= nxt;
  end

  AST_INT_FROM_CHECK: assert property (@(posedge clk) disable iff (rst)
    (state == S_NA) |-> ($past(state) == S_CK && $past(irq) && $past(ien))); // R8
  AST_NO_INT_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (state == S_CK && !(irq && ien)) |=> (state == S_FA)); // R8
endmodule

// File: rtl/isc_dp.sv
module isc_dp
  import isc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] SAVE_ADDR = '0,
  parameter logic [AW-1:0] HANDLER_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  isc_state_e    state,
  input  logic [2:0]    op,
  input  logic          ie_set,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] sum,
  input  logic          cout,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic          flag_z,
  output logic          flag_c,
  output logic          ien,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          int_done
);
  localparam int PADW = DW - AW;

  logic [AW-1:0] ea;
  assign ea = mbr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; mar <= '0; mbr <= '0; ir <= '0; acc <= '0;
      flag_z <= 1'b0; flag_c <= 1'b0; ien <= 1'b0;
      mem_rd <= 1'b0; mem_wr <= 1'b0; int_done <= 1'b0;
    end else begin
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      int_done <= 1'b0;
      if (ie_set) ien <= 1'b1;
      unique case (state)
        S_FA: begin
          mar    <= pc;
          mem_rd <= 1'b1;
          pc     <= pc + 1'b1;
        end
        S_FC, S_IC, S_XC: mbr <= mem_rdata;
        S_FI: ir <= mbr;
        S_IA: begin
          mar    <= ea;
          mem_rd <= 1'b1;
        end
        S_XA: begin
          if (op == OP_LDA || op == OP_ADD) begin
            mar    <= ea;
            mem_rd <= 1'b1;
          end else if (op == OP_STA) begin
            mar    <= ea;
            mbr    <= acc;
            mem_wr <= 1'b1;
          end else if (op == OP_JMP) begin
            pc <= ea;
          end
        end
        S_XD: begin
          if (op == OP_LDA) begin
            acc    <= mbr;
            flag_z <= (mbr == '0);
          end else if (op == OP_ADD) begin
            acc    <= sum;
            flag_z <= (sum == '0);
            flag_c <= cout;
          end
        end
        S_NA: mbr <= {{PADW{1'b0}}, pc};
        S_NB: begin
          mar    <= SAVE_ADDR;
          mem_wr <= 1'b1;
        end
        S_NC: begin
          pc       <= HANDLER_ADDR;
          ien      <= 1'b0;
          int_done <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R10
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == S_FA) |=> (pc == $past(pc) + 1'b1) && mem_rd); // R2
  AST_IND_ADDR: assert property (@(posedge clk) disable iff (rst)
    (state == S_IA) |=> (mem_rd && mar == $past(mbr[AW-1:0]))); // R3
  AST_SAVE_PC: assert property (@(posedge clk) disable iff (rst)
    (state == S_NB) |=> (mem_wr && mar == SAVE_ADDR && mbr[AW-1:0] == $past(pc))); // R9
  AST_HANDLER: assert property (@(posedge clk) disable iff (rst)
    (state == S_NC) |=> (pc == HANDLER_ADDR && !ien && int_done)); // R9
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import isc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] SAVE_ADDR = '0,
  parameter logic [AW-1:0] HANDLER_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  input  logic          ie_set,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic          flag_z,
  output logic          flag_c,
  output logic          ien,
  output logic          int_done
);
  localparam int OPW = 3;

  isc_state_e    state;
  logic [AW-1:0] mar;
  logic [DW-1:0] mbr;
  logic [DW-1:0] sum;
  logic          cout;
  logic [2:0]    op;
  logic          ind;

  assign op        = ir[DW-1 -: OPW];
  assign ind       = mbr[AW];
  assign mem_addr  = mar;
  assign mem_wdata = mbr;

  isc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .op(op), .ind(ind),
    .irq(irq), .ien(ien), .state(state)
  );

  isc_alu #(.DW(DW)) u_alu (
    .a(acc), .b(mbr), .sum(sum), .cout(cout)
  );

  isc_dp #(
    .AW(AW), .DW(DW), .SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)
  ) u_dp (
    .clk(clk), .rst(rst), .state(state), .op(op), .ie_set(ie_set),
    .mem_rdata(mem_rdata), .sum(sum), .cout(cout),
    .pc(pc), .mar(mar), .mbr(mbr), .ir(ir), .acc(acc),
    .flag_z(flag_z), .flag_c(flag_c), .ien(ien),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .int_done(int_done)
  );
endmodule

// File: tb/sim_instr_cycle_seq.sv
module sim_instr_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        ie_set = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [11:0] mem_addr, pc;
  logic [15:0] mem_wdata, ir, acc;
  logic        mem_rd, mem_wr, flag_z, flag_c, ien, int_done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  instr_cycle_seq u0 (
    .clk(clk), .rst(rst), .irq(irq), .ie_set(ie_set), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc(pc), .ir(ir), .acc(acc), .flag_z(flag_z), .flag_c(flag_c),
    .ien(ien), .int_done(int_done)
  );

  // environment memory
  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  // reference model state
  logic [15:0] rm [0:255];
  int mpc, macc, mz, mc, mie;
  int wq_addr[$];
  int wq_data[$];
  string wq_tag[$];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-clock port monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && mem_wr) begin
        total++; bad++;
        $display("FAIL R10 actual=rd&wr expected=exclusive");
      end
      if (mem_wr) begin
        if (wq_addr.size() == 0) begin
          total++; bad++;
          $display("FAIL R6 actual=write@%0h expected=none", mem_addr);
        end else begin
          string t;
          int a, d;
          t = wq_tag.pop_front();
          a = wq_addr.pop_front();
          d = wq_data.pop_front();
          chk({t, " write addr"}, mem_addr, a);
          chk({t, " write data"}, mem_wdata, d);
        end
      end
    end
  end

  task automatic run(input bit set_ie);
    int ins, op, ind, ea, cyc, s, exp_done;
    ins = rm[mpc[7:0]];
    op = (ins >> 13) & 7;
    ind = (ins >> 12) & 1;
    ea = ins & 12'hFFF;
    mpc = (mpc + 1) & 12'hFFF;
    if (ind) ea = rm[ea[7:0]] & 12'hFFF;
    cyc = 4 + (ind ? 3 : 0) + 1;
    if (set_ie) mie = 1;
    case (op)
      1: begin macc = rm[ea[7:0]]; mz = (macc == 0); cyc += 4; end
      2: begin
        rm[ea[7:0]] = macc[15:0];
        wq_addr.push_back(ea); wq_data.push_back(macc); wq_tag.push_back("R6");
        cyc += 1;
      end
      3: begin
        s = macc + rm[ea[7:0]];
        macc = s & 16'hFFFF; mc = (s >> 16) & 1; mz = (macc == 0); cyc += 4;
      end
      4: begin mpc = ea; cyc += 1; end
      default: cyc += 1;
    endcase
    exp_done = 0;
    if (irq && mie) begin
      rm[0] = mpc[15:0];
      wq_addr.push_back(0); wq_data.push_back(mpc); wq_tag.push_back("R9");
      mpc = 1; mie = 0; cyc += 3; exp_done = 1;
    end
    if (set_ie) ie_set = 1'b1;
    @(negedge clk);
    ie_set = 1'b0;
    repeat (cyc - 1) @(negedge clk);
    chk("R2 ir", ir, ins);
    chk(op == 4 ? "R7 pc" : "R2 pc", pc, mpc);
    chk(op == 3 ? "R5 acc" : "R4 acc", acc, macc);
    chk(op == 3 ? "R5 flag_z" : "R4 flag_z", flag_z, mz);
    chk(op == 1 ? "R4 flag_c kept" : "R5 flag_c", flag_c, mc);
    chk("R10 ien", ien, mie);
    chk(exp_done ? "R9 int_done" : "R8 int_done", int_done, exp_done);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h00] = 16'h8010;          // jump 0x010
    mem[8'h01] = 16'h60F1;          // handler: add [0F1]
    mem[8'h02] = 16'h9000;          // handler: jump indirect via 0x000
    mem[8'h10] = 16'h20A0;          // load 0
    mem[8'h11] = 16'h20A1;          // load 0x8001
    mem[8'h12] = 16'h60A2;          // add 0x8000 -> 1, carry
    mem[8'h13] = 16'h70A3;          // add indirect -> 0xFFFF -> 0, carry
    mem[8'h14] = 16'h40B0;          // store direct
    mem[8'h15] = 16'h20A5;          // load 0x1234
    mem[8'h16] = 16'h50A6;          // store indirect -> 0x0B1
    mem[8'h17] = 16'h0000;          // no-op
    mem[8'h18] = 16'hE0A0;          // unused code
    mem[8'h19] = 16'h8020;          // jump 0x020
    mem[8'h20] = 16'h30A3;          // load indirect -> 0xFFFF
    mem[8'h21] = 16'h0000;
    mem[8'h22] = 16'h0000;
    mem[8'h23] = 16'h20A5;
    mem[8'h24] = 16'h0000;
    mem[8'h25] = 16'h40B2;
    mem[8'hA0] = 16'h0000;
    mem[8'hA1] = 16'h8001;
    mem[8'hA2] = 16'h8000;
    mem[8'hA3] = 16'h00A4;
    mem[8'hA4] = 16'hFFFF;
    mem[8'hA5] = 16'h1234;
    mem[8'hA6] = 16'h00B1;
    mem[8'hF1] = 16'h0002;
    for (int i = 0; i < 256; i++) rm[i] = mem[i];
    mpc = 0; macc = 0; mz = 0; mc = 0; mie = 0;

    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 ir", ir, 0);
    chk("R1 acc", acc, 0);
    chk("R1 flags", {flag_z, flag_c}, 0);
    chk("R1 ien", ien, 0);
    chk("R1 mem strobes", {mem_rd, mem_wr, int_done}, 0);
    rst = 1'b0;

    for (int k = 0; k < 12; k++) run(1'b0);   // 0x00, 0x10..0x19, 0x20
    irq = 1'b1;
    run(1'b0);                                // 0x21: request while disabled (R8)
    run(1'b1);                                // 0x22: enable, entry after it (R9)
    run(1'b0);                                // handler add, request still held (R8)
    run(1'b0);                                // return via saved address
    irq = 1'b0;
    run(1'b1);                                // 0x23: enabled, no request
    irq = 1'b1;
    run(1'b0);                                // 0x24: entry
    irq = 1'b0;
    run(1'b0);                                // handler add
    run(1'b0);                                // return
    run(1'b0);                                // 0x25 store
    repeat (2) @(negedge clk);
    chk("R6 mem B0", mem[8'hB0], 16'h0000);
    chk("R6 mem B1", mem[8'hB1], 16'h1234);
    chk("R9 saved pc", mem[8'h00], 16'h0025);
    chk("R6 writes drained", wq_addr.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule